// File: doc/BRIEF.md
# Pixel Stream Latency Aligner

The aligner holds back an original pixel stream so that each pixel comes out alongside the matching pixel of a processed stream. The processed stream comes from upstream line-buffered logic and arrives later, by a delay that is not known ahead of time and can span several video lines. The original pixels go into a FIFO. The processed stream's own control signals decide when each stored pixel leaves. The output is the delayed original pixel, paired with the processed stream's timing signals. A downstream stage, such as an overlay mixer, can then combine the two streams pixel for pixel.

Alignment is tied to frame boundaries. Storage begins with the first valid input pixel that carries a frame-start mark. Release begins with the first valid reference cycle that carries a frame-start mark. After that, every valid input cycle stores one pixel and every valid reference cycle releases one pixel. The target raster is 320x240 active pixels inside a 402x324 blanked raster, so the default FIFO holds 2048 pixels. That is more than four active lines. The FIFO depth must be a power of two. If the FIFO is asked to store while full, or to release while empty, a sticky error flag is set and stays set until reset.

Top module: `pixel_stream_aligner`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `err_sticky` is 0 and the FIFO is empty.
- R2: In every cycle, `out_valid`, `out_hstart`, `out_hend`, `out_vstart` and `out_vend` equal `ref_valid`, `ref_hstart`, `ref_hend`, `ref_vstart` and `ref_vend` in that same cycle.
- R3: Valid input pixels that arrive before the first cycle after reset with `in_valid`=1 and `in_vstart`=1 are discarded. The first pixel released is the pixel of that frame-start cycle.
- R4: After the lock, exactly one pixel is stored per cycle with `in_valid`=1. Pixels are released in the order they were stored. Cycles with `in_valid`=0 store nothing.
- R5: A pixel is released in the same cycle as a valid reference cycle, and `out_pix` shows it in that cycle. `out_pix` is 0 in every cycle that releases nothing. Valid reference cycles before the first one with `ref_vstart`=1 release nothing.
- R6: A release requested while the FIFO is empty removes nothing. `out_pix` is 0 in that cycle, and `err_sticky` is 1 from the next cycle.
- R7: A store requested while the FIFO holds DEPTH pixels and no release happens in that cycle is dropped. The stored pixels are unchanged, and `err_sticky` is 1 from the next cycle.
- R8: Once `err_sticky` is 1, it stays 1 until reset.
- R9: A store and a release in the same cycle while the FIFO is full both take effect and raise no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_pix | input | PIX_W | Original pixel |
| in_valid | input | 1 | Original pixel is valid |
| in_vstart | input | 1 | Original pixel is the first of a frame |
| ref_valid | input | 1 | Reference stream valid |
| ref_hstart | input | 1 | Reference line start |
| ref_hend | input | 1 | Reference line end |
| ref_vstart | input | 1 | Reference frame start |
| ref_vend | input | 1 | Reference frame end |
| out_pix | output | PIX_W | Delayed original pixel |
| out_valid | output | 1 | Output valid (reference timing) |
| out_hstart | output | 1 | Output line start |
| out_hend | output | 1 | Output line end |
| out_vstart | output | 1 | Output frame start |
| out_vend | output | 1 | Output frame end |
| err_sticky | output | 1 | Overflow or underflow has happened |

## Verification
A corrupted pointer or fill count shows on `out_pix` at the next valid reference cycle, as a wrong or repeated pixel value. A wrong fill count also shows one cycle later as a spurious or missing `err_sticky`. A wrong frame-lock state shows up as a shifted pixel sequence: all released pixels are offset by a constant from the first release onward. The bench therefore compares `out_pix` and the flag against a queue model in every cycle. The main run uses a multi-line delay, so an error is caught within one cycle of its first visible effect.

// File: rtl/aligner_pkg.sv
package aligner_pkg;

    typedef struct packed {
        logic valid;
        logic hstart;
        logic hend;
        logic vstart;
        logic vend;
    } strm_ctrl_t;

    function automatic logic frame_begins(input logic valid, input logic vstart);
        return valid && vstart;
    endfunction

endpackage

// File: rtl/align_frame_gate.sv
module align_frame_gate
    import aligner_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic valid,
    input  logic vstart,
    output logic pass
);
    logic locked;

    always_ff @(posedge clk) begin
        if (rst)
            locked <= 1'b0;
        else if (frame_begins(valid, vstart))
            locked <= 1'b1;
    end

    assign pass = valid && (vstart || locked);
endmodule

// File: rtl/align_fifo.sv
module align_fifo #(
    parameter int PIX_W = 8,
    parameter int DEPTH = 2048
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_req,
    input  logic [PIX_W-1:0]            wr_data,
    input  logic                        rd_req,
    output logic [PIX_W-1:0]            head,
    output logic                        rd_ok,
    output logic [$clog2(DEPTH+1)-1:0]  fill,
    output logic                        overflow,
    output logic                        underflow
);
    localparam int ADDR_W = $clog2(DEPTH);
    localparam int FILL_W = $clog2(DEPTH+1);

    logic [PIX_W-1:0]  mem [DEPTH];
    logic [ADDR_W-1:0] wr_ptr, rd_ptr;
    logic              empty, full, push;

    assign empty     = (fill == '0);
    assign full      = (fill == FILL_W'(DEPTH));
    assign rd_ok     = rd_req && !empty;
    assign push      = wr_req && !(full && !rd_ok);
    assign overflow  = wr_req && full && !rd_ok;
    assign underflow = rd_req && empty;
    assign head      = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push)
            mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push)
                wr_ptr <= wr_ptr + 1'b1;
            if (rd_ok)
                rd_ptr <= rd_ptr + 1'b1;
            case ({push, rd_ok})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end
endmodule

// File: rtl/align_err.sv
module align_err (
    input  logic clk,
    input  logic rst,
    input  logic overflow,
    input  logic underflow,
    output logic err
);
    always_ff @(posedge clk) begin
        if (rst)
            err <= 1'b0;
        else if (overflow || underflow)
            err <= 1'b1;
    end
endmodule

// File: rtl/pixel_stream_aligner.sv
module pixel_stream_aligner
    import aligner_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int DEPTH = 2048
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PIX_W-1:0] in_pix,
    input  logic             in_valid,
    input  logic             in_vstart,
    input  logic             ref_valid,
    input  logic             ref_hstart,
    input  logic             ref_hend,
    input  logic             ref_vstart,
    input  logic             ref_vend,
    output logic [PIX_W-1:0] out_pix,
    output logic             out_valid,
    output logic             out_hstart,
    output logic             out_hend,
    output logic             out_vstart,
    output logic             out_vend,
    output logic             err_sticky
);
    localparam int FILL_W = $clog2(DEPTH+1);

    strm_ctrl_t        ref_ctrl;
    logic              wr_req, rd_req, rd_ok, ovf, unf;
    logic [PIX_W-1:0]  head;
    logic [FILL_W-1:0] fill;

    assign ref_ctrl = '{valid: ref_valid, hstart: ref_hstart, hend: ref_hend,
                        vstart: ref_vstart, vend: ref_vend};

    align_frame_gate u_wr_gate (
        .clk(clk), .rst(rst), .valid(in_valid), .vstart(in_vstart), .pass(wr_req)
    );

    align_frame_gate u_rd_gate (
        .clk(clk), .rst(rst), .valid(ref_ctrl.valid), .vstart(ref_ctrl.vstart), .pass(rd_req)
    );

    align_fifo #(.PIX_W(PIX_W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst),
        .wr_req(wr_req), .wr_data(in_pix),
        .rd_req(rd_req), .head(head), .rd_ok(rd_ok),
        .fill(fill), .overflow(ovf), .underflow(unf)
    );

    align_err u_err (
        .clk(clk), .rst(rst), .overflow(ovf), .underflow(unf), .err(err_sticky)
    );

    assign out_pix    = rd_ok ? head : '0;
    assign out_valid  = ref_ctrl.valid;
    assign out_hstart = ref_ctrl.hstart;
    assign out_hend   = ref_ctrl.hend;
    assign out_vstart = ref_ctrl.vstart;
    assign out_vend   = ref_ctrl.vend;
endmodule

// File: rtl/aligner_checker.sv
module aligner_checker #(
    parameter int PIX_W = 8,
    parameter int DEPTH = 2048
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       in_valid,
    input logic                       ref_valid,
    input logic                       ref_vstart,
    input logic                       out_valid,
    input logic [PIX_W-1:0]           out_pix,
    input logic                       err_sticky,
    input logic [$clog2(DEPTH+1)-1:0] fill
);
    localparam int FILL_W = $clog2(DEPTH+1);

    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> (!err_sticky && fill == '0));

    p_err_holds_r8: assert property (@(posedge clk) disable iff (rst)
        err_sticky |=> err_sticky);

    p_idle_zero_r5: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> out_pix == '0);

    p_no_underflow_r6: assert property (@(posedge clk) disable iff (rst)
        (ref_valid && ref_vstart && fill == '0) |=> err_sticky);

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        (fill == FILL_W'(DEPTH) && in_valid && !ref_valid) |=> err_sticky);

    p_fill_bound_r4: assert property (@(posedge clk) disable iff (rst)
        fill <= FILL_W'(DEPTH));

    p_fill_step_r4: assert property (@(posedge clk) disable iff (rst)
        (fill == $past(fill)) || (fill == $past(fill) + 1'b1) || (fill == $past(fill) - 1'b1));
endmodule

bind pixel_stream_aligner aligner_checker #(.PIX_W(PIX_W), .DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .ref_valid(ref_valid),
    .ref_vstart(ref_vstart), .out_valid(out_valid), .out_pix(out_pix),
    .err_sticky(err_sticky), .fill(fill)
);

// File: tb/tb_pixel_stream_aligner.sv
module tb_pixel_stream_aligner;
    localparam int PW  = 8;
    localparam int DEP = 64;
    localparam int LAT = 35;

    logic clk = 0;
    logic rst = 1;
    logic [PW-1:0] in_pix = '0;
    logic in_valid = 0, in_vstart = 0;
    logic ref_valid = 0, ref_hstart = 0, ref_hend = 0, ref_vstart = 0, ref_vend = 0;
    logic [PW-1:0] out_pix;
    logic out_valid, out_hstart, out_hend, out_vstart, out_vend, err_sticky;

    pixel_stream_aligner #(.PIX_W(PW), .DEPTH(DEP)) dut (.*);

    always #10 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    string cur = "R1";

    logic [PW-1:0] q[$];
    bit wl = 0, rl = 0, merr = 0;

    // control code bits: [4] valid, [3] hstart, [2] hend, [1] vstart, [0] vend
    localparam logic [4:0] IDLE = 5'b00000, V = 5'b10000, VS = 5'b10010;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [4:0] ras(input int t);
        int x, y;
        logic v;
        if (t < 0) return 5'b0;
        x = t % 14;
        y = (t / 14) % 9;
        v = (x < 10) && (y < 6);
        return {v, v && x == 0, v && x == 9, v && x == 0 && y == 0, v && x == 9 && y == 5};
    endfunction

    task automatic step(input logic [4:0] ic, input logic [PW-1:0] ip, input logic [4:0] rc);
        bit pop, wr, under, over;
        int epix;
        @(negedge clk);
        in_pix = ip;
        in_valid = ic[4];
        in_vstart = ic[1];
        {ref_valid, ref_hstart, ref_hend, ref_vstart, ref_vend} = rc;
        #2;
        pop   = rc[4] && (rc[1] || rl);
        wr    = ic[4] && (ic[1] || wl);
        under = pop && q.size() == 0;
        epix  = (pop && !under) ? int'(q[0]) : 0;
        over  = wr && q.size() == DEP && !pop;
        chk(cur, "out_pix", int'(out_pix), epix);
        chk("R2", "out_ctrl", int'({out_valid, out_hstart, out_hend, out_vstart, out_vend}), int'(rc));
        chk(cur, "err_sticky", int'(err_sticky), int'(merr));
        if (pop && !under) void'(q.pop_front());
        if (wr && !over) q.push_back(ip);
        if (ic[4] && ic[1]) wl = 1;
        if (rc[4] && rc[1]) rl = 1;
        merr = merr | under | over;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1;
        in_valid = 0; in_vstart = 0;
        {ref_valid, ref_hstart, ref_hend, ref_vstart, ref_vend} = 5'b0;
        repeat (2) @(negedge clk);
        #2;
        chk("R1", "err_sticky in reset", int'(err_sticky), 0);
        rst = 0;
        q.delete(); wl = 0; rl = 0; merr = 0;
    endtask

    initial begin
        do_reset();
        cur = "R1";
        step(IDLE, 8'h00, IDLE);
        step(IDLE, 8'h00, IDLE);

        // R3: pre-frame pixels discarded; R4: gaps store nothing
        cur = "R3";
        step(V, 8'd1, IDLE);
        step(V, 8'd2, IDLE);
        step(V, 8'd3, IDLE);
        cur = "R4";
        step(VS, 8'd10, IDLE);
        step(V, 8'd11, IDLE);
        step(IDLE, 8'd99, IDLE);
        step(V, 8'd12, IDLE);
        step(IDLE, 8'd98, IDLE);
        step(V, 8'd13, IDLE);
        step(V, 8'd14, IDLE);
        // R5: reference valid before its frame start releases nothing
        cur = "R5";
        step(IDLE, 8'd0, V);
        step(IDLE, 8'd0, 5'b11000);
        cur = "R3";
        step(IDLE, 8'd0, 5'b11010);
        cur = "R4";
        step(IDLE, 8'd0, V);
        step(IDLE, 8'd0, IDLE);
        step(IDLE, 8'd0, V);
        step(IDLE, 8'd0, 5'b10100);
        step(IDLE, 8'd0, V);
        // R6: underflow
        cur = "R6";
        step(IDLE, 8'd0, V);
        step(IDLE, 8'd0, IDLE);
        // R8: sticky
        cur = "R8";
        step(V, 8'd50, IDLE);
        step(IDLE, 8'd0, V);
        step(IDLE, 8'd0, IDLE);

        // R7: overflow
        do_reset();
        cur = "R7";
        step(VS, 8'd0, IDLE);
        for (int i = 1; i < DEP + 3; i++) step(V, 8'(i), IDLE);
        step(IDLE, 8'd0, VS);
        for (int i = 1; i < DEP; i++) step(IDLE, 8'd0, V);
        step(IDLE, 8'd0, IDLE);

        // R9: full with simultaneous store and release
        do_reset();
        cur = "R9";
        step(VS, 8'd100, IDLE);
        for (int i = 1; i < DEP; i++) step(V, 8'(100 + i), IDLE);
        step(V, 8'd7, VS);
        for (int i = 0; i < 5; i++) step(V, 8'(200 + i), V);
        step(IDLE, 8'd0, IDLE);

        // R4/R3: multi-line delay over a blanked raster
        do_reset();
        cur = "R4";
        for (int t = 0; t < 600; t++) step(ras(t + 50), 8'(t), ras(t + 50 - LAT));

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule